// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Register Front End

This block is the digital side of a 12-bit voltage-output converter that a small microcontroller drives over a byte-wide parallel bus. The host selects the block with an active-low chip select, pulses an active-low write enable and puts a 2-bit address on the bus. The address chooses one of three targets: a low-byte holding register, a high-nibble holding register or a control register. A write to a holding register leaves the converter code as it is. A separate active-low load input moves the assembled 12-bit holding value into the DAC latch, so all twelve bits of the output code change together.

The control register chooses the reference source: external, internal low level or internal high level. It also holds a fast-settling bit. The block decodes these into the enable and level-select lines of the reference output buffer and into a fast-mode line. A dedicated speed pin can also force fast mode. An active-low power-down pin drives the analog power-down output directly and leaves the register contents untouched. An asynchronous active-low reset stands in for power-on reset and clears every latch. All bus strobes and pins pass through two-flop synchronizers. A small write state machine turns each strobe assertion into exactly one register write. Its states are WS_IDLE (waiting for a strobe), WS_CAPTURE (the single write cycle) and WS_WAIT_REL (waiting for the strobe to be released). Its transitions are IDLE→CAPTURE on strobe, CAPTURE→WAIT_REL while the strobe stays active, CAPTURE→IDLE on early release, and WAIT_REL→IDLE on release.

Top module: `dac_bus_front`

## Requirements
- R1: After reset, dac_code is 0, ref_out_en and ref_hi_sel are 0 (external reference), fast_mode is 0, and pwr_dn is 0 while pd_n is high.
- R2: A write with addr 00 loads din[7:0] into holding bits 7:0. A write with addr 01 loads din[3:0] into holding bits 11:8. A write with addr 10 loads din[2:0] into the control register, and din[7:3] is ignored. Each write leaves the other registers unchanged.
- R3: A write with addr 11 changes no register.
- R4: One assertion of the strobe performs exactly one write. Bus values that change while the strobe stays low are not written.
- R5: While ld_n is high, holding-register writes do not change dac_code.
- R6: While ld_n is low, dac_code follows the 12-bit holding value each clock, so a write made during load reaches dac_code.
- R7: Control bits [1:0] decode as follows: 01 gives ref_out_en=1 and ref_hi_sel=0; 10 gives ref_out_en=1 and ref_hi_sel=1; 00 and 11 give ref_out_en=0 and ref_hi_sel=0.
- R8: fast_mode is control bit 2 OR the spd_pin input.
- R9: pd_n low sets pwr_dn to 1 whatever the registers hold, and it does not alter dac_code or the control register.
- R10: A write happens only when cs_n and we_n are low together. A low cs_n with we_n high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| din | input | 8 | Write data byte |
| ld_n | input | 1 | Active-low level-sensitive DAC latch load |
| spd_pin | input | 1 | Forces fast settling when high |
| pd_n | input | 1 | Active-low hardware power-down |
| dac_code | output | 12 | Code driven to the converter |
| ref_out_en | output | 1 | Internal reference and its output buffer enabled |
| ref_hi_sel | output | 1 | Internal reference at its high level |
| fast_mode | output | 1 | Fast settling selected |
| pwr_dn | output | 1 | Analog power-down request |

## Verification
The assertions assume that addr and din stay stable while cs_n and we_n are both low. They also assume that each strobe and pin level lasts at least two clocks, so that the synchronizers see it. The bench holds every strobe low for four clocks with the bus steady. It waits several clocks between operations, except in the held-strobe case, which changes the data deliberately to show that no second write occurs. Random phases mix writes to all four addresses, load toggles, and speed and power-down pin levels, all within these limits.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    typedef enum logic [1:0] {
        WS_IDLE     = 2'd0,
        WS_CAPTURE  = 2'd1,
        WS_WAIT_REL = 2'd2
    } wr_state_e;

    localparam logic [1:0] ADDR_LO   = 2'b00;
    localparam logic [1:0] ADDR_HI   = 2'b01;
    localparam logic [1:0] ADDR_CTL  = 2'b10;

    localparam logic [1:0] REF_EXT   = 2'b00;
    localparam logic [1:0] REF_INT_L = 2'b01;
    localparam logic [1:0] REF_INT_H = 2'b10;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dac_fe_wr_fsm.sv
module dac_fe_wr_fsm
    import dac_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic wr_pulse
);
    wr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE:     if (strobe)  state_nx = WS_CAPTURE;
            WS_CAPTURE:  state_nx = strobe ? WS_WAIT_REL : WS_IDLE;
            WS_WAIT_REL: if (!strobe) state_nx = WS_IDLE;
            default:     state_nx = WS_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse = (state == WS_CAPTURE);
    end

    assert_one_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    assert_write_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(strobe));
endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
    import dac_fe_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CW   = 12,
    parameter int CTLW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [DW-1:0]   din,
    input  logic            ld_act,
    output logic [CW-1:0]   dac_code,
    output logic [CTLW-1:0] ctl_q
);
    localparam int HW = CW - DW;

    logic [DW-1:0] hold_lo;
    logic [HW-1:0] hold_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_lo <= '0;
            hold_hi <= '0;
            ctl_q   <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_LO:  hold_lo <= din;
                ADDR_HI:  hold_hi <= din[HW-1:0];
                ADDR_CTL: ctl_q   <= din[CTLW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dac_code <= '0;
        else if (ld_act) dac_code <= {hold_hi, hold_lo};
    end

    assert_addr3_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'b11) |=> ($stable(hold_lo) && $stable(hold_hi) && $stable(ctl_q)));

    assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_LO) |=> ($stable(hold_hi) && $stable(ctl_q)));

    assert_hold_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_act |=> $stable(dac_code));
endmodule

// File: rtl/dac_bus_front.sv
module dac_bus_front
    import dac_fe_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CW       = 12,
    parameter int SYNC_STG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          we_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    input  logic          ld_n,
    input  logic          spd_pin,
    input  logic          pd_n,
    output logic [CW-1:0] dac_code,
    output logic          ref_out_en,
    output logic          ref_hi_sel,
    output logic          fast_mode,
    output logic          pwr_dn
);
    localparam int CTLW = 3;
    localparam int NSYN = 5;

    logic [NSYN-1:0] pins_s;
    logic cs_s, we_s, ld_s, spd_s, pd_s;
    logic wr_pulse;
    logic [CTLW-1:0] ctl_q;

    dac_fe_sync #(.W(NSYN), .STAGES(SYNC_STG), .RST_VAL(5'b11101)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, we_n, ld_n, spd_pin, pd_n}),
        .q(pins_s)
    );
    assign {cs_s, we_s, ld_s, spd_s, pd_s} = pins_s;

    dac_fe_wr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .strobe(!cs_s && !we_s),
        .wr_pulse(wr_pulse)
    );

    dac_fe_regs #(.DW(DW), .CW(CW), .CTLW(CTLW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_pulse), .addr(addr), .din(din),
        .ld_act(!ld_s),
        .dac_code(dac_code), .ctl_q(ctl_q)
    );

    always_comb begin
        ref_out_en = 1'b0;
        ref_hi_sel = 1'b0;
        unique case (ctl_q[1:0])
            REF_INT_L: ref_out_en = 1'b1;
            REF_INT_H: begin ref_out_en = 1'b1; ref_hi_sel = 1'b1; end
            default:   ;
        endcase
        fast_mode = ctl_q[2] | spd_s;
        pwr_dn    = !pd_s;
    end

    assert_ref_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hi_sel |-> ref_out_en);

    assert_pd_keeps_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && ld_n && $past(ld_n)) |=> $stable(dac_code));
endmodule

// File: tb/dac_bus_front_bench.sv
module dac_bus_front_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, we_n = 1'b1, ld_n = 1'b1, spd_pin = 1'b0, pd_n = 1'b1;
    logic [1:0] addr = 2'b00;
    logic [7:0] din = 8'h00;
    logic [11:0] dac_code;
    logic ref_out_en, ref_hi_sel, fast_mode, pwr_dn;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0]  m_lo = '0;
    logic [3:0]  m_hi = '0;
    logic [2:0]  m_ctl = '0;
    logic [11:0] m_dac = '0;

    always #5 clk = ~clk;

    dac_bus_front u_dac_bus_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr), .din(din),
        .ld_n(ld_n), .spd_pin(spd_pin), .pd_n(pd_n), .dac_code(dac_code),
        .ref_out_en(ref_out_en), .ref_hi_sel(ref_hi_sel),
        .fast_mode(fast_mode), .pwr_dn(pwr_dn)
    );

    function automatic logic exp_ref_en(input logic [2:0] c);
        return (c[1:0] == 2'b01) || (c[1:0] == 2'b10);
    endfunction

    function automatic logic exp_ref_hi(input logic [2:0] c);
        return c[1:0] == 2'b10;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'b00: m_lo = d;
            2'b01: m_hi = d[3:0];
            2'b10: m_ctl = d[2:0];
            default: ;
        endcase
        if (!ld_n) m_dac = {m_hi, m_lo};
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        addr = a; din = d;
        cs_n = 1'b0; we_n = 1'b0;
        wait_cyc(4);
        cs_n = 1'b1; we_n = 1'b1;
        wait_cyc(4);
        model_write(a, d);
    endtask

    task automatic set_load(input logic v);
        ld_n = v;
        wait_cyc(4);
        if (!ld_n) m_dac = {m_hi, m_lo};
    endtask

    task automatic check_all(input string req);
        check(req, dac_code, m_dac);
        check(req, ref_out_en, exp_ref_en(m_ctl));
        check(req, ref_hi_sel, exp_ref_hi(m_ctl));
        check(req, fast_mode, m_ctl[2] | spd_pin);
        check(req, pwr_dn, !pd_n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_cyc(3);
        // R1 reset state
        check_all("R1");
        rst_n = 1'b1;
        wait_cyc(3);
        check_all("R1");

        // R2, R5: holding writes, code unchanged with ld_n high
        bus_write(2'b00, 8'hA5);
        bus_write(2'b01, 8'hF3);
        check("R5", dac_code, 12'h000);
        // R6: load copies 12 bits
        set_load(1'b0);
        check("R2", dac_code, 12'h3A5);
        check_all("R6");
        // R6 pass-through while load held low
        bus_write(2'b00, 8'h5C);
        check("R6", dac_code, 12'h35C);
        set_load(1'b1);

        // R3: address 11 ignored
        bus_write(2'b11, 8'hFF);
        check_all("R3");
        set_load(1'b0);
        check("R3", dac_code, 12'h35C);
        set_load(1'b1);

        // R4: held strobe, data changes mid-strobe
        addr = 2'b00; din = 8'h11;
        cs_n = 1'b0; we_n = 1'b0;
        wait_cyc(4);
        din = 8'h99;
        wait_cyc(4);
        cs_n = 1'b1; we_n = 1'b1;
        wait_cyc(4);
        model_write(2'b00, 8'h11);
        set_load(1'b0);
        check("R4", dac_code, 12'h311);
        set_load(1'b1);

        // R10: chip select alone writes nothing
        addr = 2'b00; din = 8'hEE; cs_n = 1'b0;
        wait_cyc(4);
        cs_n = 1'b1;
        wait_cyc(4);
        we_n = 1'b0;
        wait_cyc(4);
        we_n = 1'b1;
        wait_cyc(4);
        set_load(1'b0);
        check("R10", dac_code, 12'h311);
        set_load(1'b1);

        // R7: every reference code, upper din bits ignored
        for (int k = 0; k < 4; k++) begin
            bus_write(2'b10, {5'b10101, 1'b0, k[1:0]});
            check("R7", ref_out_en, (k == 1) || (k == 2));
            check("R7", ref_hi_sel, k == 2);
            check("R2", fast_mode, 1'b0);
        end

        // R8: speed bit OR pin
        spd_pin = 1'b1; wait_cyc(4);
        check("R8", fast_mode, 1'b1);
        bus_write(2'b10, 8'h04);
        spd_pin = 1'b0; wait_cyc(4);
        check("R8", fast_mode, 1'b1);
        bus_write(2'b10, 8'h01);
        check("R8", fast_mode, 1'b0);

        // R9: power-down forces output, contents kept
        pd_n = 1'b0; wait_cyc(4);
        check("R9", pwr_dn, 1'b1);
        check("R9", dac_code, m_dac);
        check("R9", ref_out_en, 1'b1);
        pd_n = 1'b1; wait_cyc(4);
        check("R9", pwr_dn, 1'b0);

        // Random phase across all requirements (R2 R3 R5 R6 R7 R8 R9)
        for (int i = 0; i < 200; i++) begin
            int op;
            op = $urandom_range(0, 5);
            if (op <= 3) bus_write(2'($urandom_range(0, 3)), 8'($urandom));
            else if (op == 4) set_load(1'($urandom_range(0, 1)));
            else begin
                spd_pin = 1'($urandom_range(0, 1));
                pd_n = 1'($urandom_range(0, 1));
                wait_cyc(4);
            end
            check_all("R6");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule